// File: doc/BRIEF.md
# Serial Management Frame Master

This block runs complete read and write transactions on a two-wire PHY management bus. A host pulses `start` with the transfer direction, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the management clock `mdc` from the system clock and shifts a 64-bit frame onto the data line: a run of ones, a 16-bit header, and 16 data bits. For a read it stops driving the data line partway through the header, takes 16 bits from the PHY and returns them on `rd_data` with a single-cycle `done` pulse.

The data line is split into an output value `mdio_o`, an output enable `mdio_oe` and a sampled input `mdio_i`, so a pad cell outside the block can form the bidirectional pin. The `mdc` half period is `HALF_DIV` system clocks. The default of 25 at a 125 MHz system clock gives 2.5 MHz. `HALF_DIV` must be at least 2.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transaction is running, `mdc`, `mdio_oe`, `busy` and `done` are 0, and `rd_data` is 0 until the first read completes.
- R2: Each frame opens with 32 bits of value 1, one bit per `mdc` period, with `mdio_oe` high.
- R3: The 16 header bits follow the preamble, first bit first: start pattern 0 then 1; opcode 1,0 for a read or 0,1 for a write; the PHY address MSB first; the register address MSB first; then two turnaround bits. The header word is 0x6000 (read) or 0x5002 (write), OR'd with the PHY address shifted left by 7 and the register address shifted left by 2.
- R4: In a write, the turnaround is driven as 1 then 0, then `wr_data` is driven MSB first. `mdio_oe` stays high for all 64 bits.
- R5: In a read, `mdio_oe` falls at the start of header bit 15 of 16, which is frame bit 46 counting from 0. It stays low until the end of the frame.
- R6: In a read, `mdio_i` is sampled in the last system clock of each `mdc`-low phase of the 16 data bits, MSB first. The word appears on `rd_data` in the `done` cycle and is held until the next read completes. A write leaves `rd_data` unchanged.
- R7: Every `mdc` low phase and every `mdc` high phase lasts `HALF_DIV` system clocks. `mdio_o` and `mdio_oe` change only in the clock where `mdc` falls, or at frame start or frame end.
- R8: The clock after the high phase of the last bit, which is `128*HALF_DIV` clocks after the accepting edge, has `done` high for exactly one clock, `busy` low, `mdc` low and `mdio_oe` low.
- R9: `busy` rises on the clock after an accepted `start` and stays high until `done`. A `start` seen while `busy` is high is ignored, and the running frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| op_read | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Data returned by the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Every output is a register, and the bench counts clocks k from the edge that accepts `start`. In clock k, `mdc` is due high when k mod 2·HALF_DIV is at least HALF_DIV. The frame bit on the line is k/(2·HALF_DIV). `done` and the new `rd_data` are due in clock 128·HALF_DIV, and `done` must be gone one clock later. The bench drives `mdio_i` for each clock from the same index, so each read bit is present in the clock where it is sampled. It compares the model's expectation with the outputs at every falling clock edge, half a cycle away from the edge that updates them.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_BITS    = 32;
    localparam int HDR_BITS    = 16;
    localparam int DAT_BITS    = 16;
    localparam int ADDR_BITS   = 5;
    localparam int FRAME_BITS  = PRE_BITS + HDR_BITS + DAT_BITS;
    localparam int IDX_W       = $clog2(FRAME_BITS);
    // bus is released from the second-to-last header bit on reads
    localparam int RELEASE_IDX = PRE_BITS + HDR_BITS - 2;
    localparam int DATA_IDX    = PRE_BITS + HDR_BITS;
    localparam logic [HDR_BITS-1:0] HDR_RD = 16'h6000;
    localparam logic [HDR_BITS-1:0] HDR_WR = 16'h5002;

    typedef logic [ADDR_BITS-1:0] addr_t;
    typedef logic [DAT_BITS-1:0]  word_t;

    function automatic logic [HDR_BITS-1:0] hdr_word(logic is_rd, addr_t phy, addr_t rg);
        return (is_rd ? HDR_RD : HDR_WR) | {4'b0, phy, 7'b0} | {9'b0, rg, 2'b0};
    endfunction

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic                  mdc;
        logic                  mdo;
        logic                  oe;
        logic                  done;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] tx;
        word_t                 rx;
        word_t                 rdat;
    } frm_state_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } gen_state_t;

    gen_state_t st_d, st_q;

    assign phase_end = run && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!run || phase_end) st_d.cnt = '0;
        else                   st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  op_read,
    input  addr_t phy_addr,
    input  addr_t reg_addr,
    input  word_t wr_data,
    input  logic  phase_end,
    input  logic  mdio_i,
    output word_t rd_data,
    output logic  busy,
    output logic  done,
    output logic  mdc,
    output logic  mdio_o,
    output logic  mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(RELEASE_IDX);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_IDX);

    frm_state_t st_d, st_q;
    logic [IDX_W-1:0] nxt_idx;

    assign nxt_idx = st_q.idx + 1'b1;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.rd   = op_read;
                st_d.idx  = '0;
                st_d.mdc  = 1'b0;
                st_d.tx   = {{PRE_BITS{1'b1}}, hdr_word(op_read, phy_addr, reg_addr),
                             op_read ? word_t'(0) : wr_data};
                st_d.mdo  = 1'b1;
                st_d.oe   = 1'b1;
            end
        end else if (phase_end) begin
            if (!st_q.mdc) begin
                // last clock of the low phase: capture read data, then rise
                st_d.mdc = 1'b1;
                if (st_q.rd && (st_q.idx >= DAT_IDX))
                    st_d.rx = {st_q.rx[DAT_BITS-2:0], mdio_i};
            end else if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.mdc  = 1'b0;
                st_d.oe   = 1'b0;
                st_d.mdo  = 1'b0;
                st_d.done = 1'b1;
                if (st_q.rd) st_d.rdat = st_q.rx;
            end else begin
                st_d.mdc = 1'b0;
                st_d.idx = nxt_idx;
                st_d.tx  = {st_q.tx[FRAME_BITS-2:0], 1'b0};
                st_d.mdo = st_q.tx[FRAME_BITS-2];
                st_d.oe  = !st_q.rd || (nxt_idx < REL_IDX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdat;
    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign mdc     = st_q.mdc;
    assign mdio_o  = st_q.mdo;
    assign mdio_oe = st_q.oe;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_read,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic        done,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic phase_end;

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .phase_end (phase_end)
    );

    mdio_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_read   (op_read),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .phase_end (phase_end),
        .mdio_i    (mdio_i),
        .rd_data   (rd_data),
        .busy      (busy),
        .done      (done),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    // R7: data line frozen while mdc stays high
    p_line_stable_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R1: idle means no clock and no drive
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R8: completion pulse lasts one clock
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion leaves the bus parked
    p_done_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mdc && !mdio_oe));

    // R9: an accepted start raises busy next clock
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9: busy only drops together with done
    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int HALF = 3;
    localparam int FR   = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_read = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        mdio_i = 1'b1;
    logic [15:0] rd_data;
    logic        busy, done, mdc, mdio_o, mdio_oe;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    logic [15:0] exp_rd = '0;

    always #4 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            miscompares++;
            $display("FAIL R8 watchdog actual=%0d expected<=100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_check(input string req);
        chk(req, "busy", {15'b0, busy}, 16'h0);
        chk(req, "done", {15'b0, done}, 16'h0);
        chk(req, "mdc", {15'b0, mdc}, 16'h0);
        chk(req, "mdio_oe", {15'b0, mdio_oe}, 16'h0);
        chk("R6", "rd_data idle", rd_data, exp_rd);
    endtask

    // poke_k >= 0: raise a conflicting start during clock poke_k (R9)
    task automatic txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input logic [15:0] pd, input int poke_k);
        logic [63:0] fr;
        fr = '0;
        for (int i = 0; i < 32; i++) fr[i] = 1'b1;
        fr[32] = 1'b0; fr[33] = 1'b1;
        fr[34] = rd;   fr[35] = !rd;
        for (int i = 0; i < 5; i++) begin
            fr[36+i] = pa[4-i];
            fr[41+i] = ra[4-i];
        end
        fr[46] = !rd; fr[47] = 1'b0;
        for (int i = 0; i < 16; i++) fr[48+i] = rd ? pd[15-i] : wd[15-i];

        @(negedge clk);
        op_read = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < FR; k++) begin
            int  b;
            logic hi, eoe;
            string tg;
            b   = k / (2 * HALF);
            hi  = (k % (2 * HALF)) >= HALF;
            eoe = !rd || (b < 46);
            if (k == poke_k) begin
                start = 1'b1; op_read = !rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
            end else begin
                start = 1'b0;
            end
            mdio_i = (rd && b >= 48) ? fr[b] : 1'b1;
            chk("R9", "busy", {15'b0, busy}, 16'h1);
            chk("R8", "done early", {15'b0, done}, 16'h0);
            chk("R7", "mdc", {15'b0, mdc}, {15'b0, hi});
            chk(rd ? "R5" : "R4", "mdio_oe", {15'b0, mdio_oe}, {15'b0, eoe});
            tg = (b < 32) ? "R2" : (b < 48) ? "R3" : "R4";
            if (eoe) chk(tg, "mdio_o", {15'b0, mdio_o}, {15'b0, fr[b]});
            chk("R6", "rd_data held", rd_data, exp_rd);
            @(negedge clk);
        end
        start = 1'b0;
        mdio_i = 1'b1;
        if (rd) exp_rd = pd;
        chk("R8", "done", {15'b0, done}, 16'h1);
        chk("R8", "busy at end", {15'b0, busy}, 16'h0);
        chk("R8", "mdc at end", {15'b0, mdc}, 16'h0);
        chk("R8", "mdio_oe at end", {15'b0, mdio_oe}, 16'h0);
        chk("R6", "rd_data result", rd_data, exp_rd);
        @(negedge clk);
        chk("R8", "done width", {15'b0, done}, 16'h0);
        idle_check("R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1");
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            idle_check("R1");
        end
        txn(1'b0, 5'd1,  5'd0,  16'hA5C3, 16'h0000, -1);
        txn(1'b1, 5'd31, 5'd31, 16'h0000, 16'h8001, -1);
        txn(1'b1, 5'd0,  5'd18, 16'h0000, 16'hFFFF, -1);
        txn(1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000, -1);
        txn(1'b0, 5'd21, 5'd10, 16'hFFFF, 16'h0000, 200);
        txn(1'b1, 5'd10, 5'd21, 16'h0000, 16'h5A3C, 290);
        txn(1'b1, 5'd3,  5'd4,  16'h1234, 16'h0001, 5);
        repeat (4) begin
            @(negedge clk);
            idle_check("R1");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule